// File: doc/BRIEF.md
# Periodic Preloaded Down-Counter Timer

This block is a 24-bit interval timer that sits on a byte-wide register bus. Software loads a start value into three preload byte registers and then sets the run bit in the control register. That write copies the preload value into the counter and restarts a divide-by-32 prescaler. After that, the counter steps down by one every 32 system clocks.

When a step brings the counter to zero, a zero-detect flag is set. The next step copies the preload value back into the counter, so the flag rises at a fixed period. Software clears the flag by writing a one to it. While the flag is set and the control register selects request mode, the block raises an interrupt request. When the acknowledge input is high, the block drives its programmed vector number.

The counter can be read as three bytes at any time. Each read returns the live value; the three bytes are not latched together.

Top module: `periodic_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq_req` is low and `vec_out` is 0.
- R2: The control register (offset 0x0), the vector register (offset 0x2) and the preload bytes read back the value last written. The preload bytes are high at 0x4, middle at 0x5 and low at 0x6. A read of an unmapped offset returns 0.
- R3: A control write that changes bit 0 from 0 to 1 loads the preload value into the counter in the same clock. The counter then reads unchanged for 31 further clocks, is one lower at the 32nd clock after the write, and falls by one every 32 clocks after that.
- R4: The counter steps only while control bit 0 is 1 and control bits 2:1 are 00. Otherwise it holds its value.
- R5: On the step that brings the counter to zero, status bit 0 (offset 0x1) is set. The following step reloads the preload value. With a preload P above 0, the first zero arrives 32·P clocks after enable and later zeros every 32·(P+1) clocks. With P = 0, the flag is set on every step.
- R6: Writing 1 to status bit 0 clears it, and writing 0 there leaves it unchanged. When a clear write and a zero step fall in the same clock, the flag stays set.
- R7: `irq_req` is high exactly when status bit 0 is set and control bits 7:5 equal 101.
- R8: `vec_out` equals the vector register while `irq_ack` is high, and is 0 otherwise.
- R9: The count bytes (high 0x8, middle 0x9, low 0xA) return the live counter value and ignore writes.
- R10: A preload write while the timer runs leaves the running count alone. The new value is used only at the next reload or enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when no read is selected) |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| vec_out | output | 8 | Vector number, driven during acknowledge |

## Verification
The zero-detect set from the counter and the software clear through the status register can land in the same clock. The bench sets this up by timing a clear write so that its clock edge is exactly the edge of a predicted zero step. Those edges follow from the 32·(P+1) period. The bench expects the request to stay high and the flag to read 1 afterwards, and then expects a later, isolated clear to drop the request.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADR_W = 4;
    localparam int BUS_W = 8;

    // register offsets
    localparam logic [ADR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADR_W-1:0] OFS_STAT = 4'h1;
    localparam logic [ADR_W-1:0] OFS_VEC  = 4'h2;
    localparam logic [ADR_W-1:0] OFS_PRE  = 4'h4;
    localparam logic [ADR_W-1:0] OFS_CNT  = 4'h8;

    localparam logic [2:0] PIN_AS_REQ = 3'b101;
    localparam logic [1:0] CLK_PRESC  = 2'b00;

    typedef struct packed {
        logic [2:0] pin_mode;   // 7:5
        logic       no_reload;  // 4
        logic       spare;      // 3
        logic [1:0] clk_sel;    // 2:1
        logic       run;        // 0
    } ctrl_t;

    function automatic logic counts_on(ctrl_t c);
        return c.run && (c.clk_sel == CLK_PRESC);
    endfunction

    function automatic logic req_mode(ctrl_t c);
        return c.pin_mode == PIN_AS_REQ;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic en,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    assign tick = en && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !en) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         tick,
    input  logic [W-1:0] preload,
    output logic [W-1:0] count,
    output logic         zero_hit
);
    logic [W-1:0] nxt;

    always_comb begin
        if (count == '0) begin
            nxt = preload;
        end else begin
            nxt = count - 1'b1;
        end
    end

    assign zero_hit = tick && (nxt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= preload;
        end else if (tick) begin
            count <= nxt;
        end
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int NB = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADR_W-1:0]  addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [NB*8-1:0]   count,
    input  logic              zero_hit,
    output logic [BUS_W-1:0]  rdata,
    output ctrl_t             ctrl_q,
    output logic [BUS_W-1:0]  vec_q,
    output logic [NB*8-1:0]   preload,
    output logic              zd_q,
    output logic              load_p
);
    logic        wr_hit;
    logic        rd_hit;
    logic        clr_zd;
    logic [7:0]  pre_b [NB];

    assign wr_hit = sel && wr;
    assign rd_hit = sel && !wr;
    assign clr_zd = wr_hit && (addr == OFS_STAT) && wdata[0];
    assign load_p = wr_hit && (addr == OFS_CTRL) && wdata[0] && !ctrl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            vec_q  <= '0;
        end else if (wr_hit) begin
            if (addr == OFS_CTRL) ctrl_q <= ctrl_t'(wdata);
            if (addr == OFS_VEC)  vec_q  <= wdata;
        end
    end

    // byte 0 is the most significant
    for (genvar i = 0; i < NB; i++) begin : g_pre
        always_ff @(posedge clk) begin
            if (rst) begin
                pre_b[i] <= '0;
            end else if (wr_hit && (addr == OFS_PRE + ADR_W'(i))) begin
                pre_b[i] <= wdata;
            end
        end
        assign preload[(NB-1-i)*8 +: 8] = pre_b[i];
    end

    // set has priority over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            zd_q <= 1'b0;
        end else if (zero_hit) begin
            zd_q <= 1'b1;
        end else if (clr_zd) begin
            zd_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            if (addr == OFS_CTRL) rdata = ctrl_q;
            if (addr == OFS_STAT) rdata = {7'b0, zd_q};
            if (addr == OFS_VEC)  rdata = vec_q;
            for (int i = 0; i < NB; i++) begin
                if (addr == OFS_PRE + ADR_W'(i)) rdata = pre_b[i];
                if (addr == OFS_CNT + ADR_W'(i)) rdata = count[(NB-1-i)*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int PRESC_DIV = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             irq_req,
    input  logic             irq_ack,
    output logic [7:0]       vec_out
);
    localparam int NB = CNT_W / 8;
    localparam int CW = NB * 8;

    ctrl_t          ctrl_q;
    logic [7:0]     vec_q;
    logic [CW-1:0]  preload;
    logic [CW-1:0]  count;
    logic           zd_q;
    logic           load_p;
    logic           tick;
    logic           zero_hit;
    logic           cnt_en;

    assign cnt_en = counts_on(ctrl_q);

    tmr_regs #(.NB(NB)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .count    (count),
        .zero_hit (zero_hit),
        .rdata    (bus_rdata),
        .ctrl_q   (ctrl_q),
        .vec_q    (vec_q),
        .preload  (preload),
        .zd_q     (zd_q),
        .load_p   (load_p)
    );

    tmr_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (load_p),
        .en      (cnt_en),
        .tick    (tick)
    );

    tmr_counter #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load_p),
        .tick     (tick),
        .preload  (preload),
        .count    (count),
        .zero_hit (zero_hit)
    );

    assign irq_req = zd_q && req_mode(ctrl_q);
    assign vec_out = irq_ack ? vec_q : 8'h00;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          sel,
    input logic          wr,
    input logic [3:0]    addr,
    input logic [7:0]    wdata,
    input logic          irq_req,
    input logic          irq_ack,
    input logic [7:0]    vec_out,
    input logic          zd,
    input logic          tick,
    input logic          load,
    input logic          cnt_en,
    input logic [CW-1:0] count
);
    // R8
    vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_ack |-> (vec_out == 8'h00));

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> zd);

    // R5
    zd_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(zd) |-> $past(tick));

    // R6
    zd_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(zd) |-> $past(sel && wr && (addr == 4'h1) && wdata[0]));

    // R3
    cnt_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(count) |-> $past(tick || load));

    // R4
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> cnt_en);
endmodule

bind periodic_timer tmr_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .irq_req (irq_req),
    .irq_ack (irq_ack),
    .vec_out (vec_out),
    .zd      (zd_q),
    .tick    (tick),
    .load    (load_p),
    .cnt_en  (cnt_en),
    .count   (count)
);

// File: tb/tb_periodic_timer.sv
module tb_periodic_timer;
    localparam int DIV = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_req;
    logic       irq_ack = 1'b0;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_edge = 0;
    bit done = 0;

    periodic_timer dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_ack   (irq_ack),
        .vec_out   (vec_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // call at a falling edge; the write lands on the next rising edge
    task automatic wr_at(input logic [3:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        last_edge = cyc + 1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_at(a, d);
    endtask

    task automatic rd_now(input logic [3:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_count(output int v);
        logic [7:0] h, m, l;
        rd_now(4'h8, h); rd_now(4'h9, m); rd_now(4'hA, l);
        v = int'({h, m, l});
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wait_irq(input int limit, output int zc);
        while (!irq_req && cyc < limit) @(negedge clk);
        zc = cyc;
    endtask

    task automatic set_pre(input int p);
        wr_reg(4'h4, 8'((p >> 16) & 255));
        wr_reg(4'h5, 8'((p >> 8) & 255));
        wr_reg(4'h6, 8'(p & 255));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int e, z1, z2, v, p, hold;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd_now(4'(a), d);
            check("R1 reg", int'(d), 0);
        end
        check("R1 irq", int'(irq_req), 0);
        irq_ack = 1'b1; #1;
        check("R1 vec", int'(vec_out), 0);
        irq_ack = 1'b0;

        // R2 readback
        wr_reg(4'h0, 8'hA0);
        wr_reg(4'h2, 8'h46);
        set_pre(32'h00A5C3);
        rd_now(4'h0, d); check("R2 ctrl", int'(d), 8'hA0);
        rd_now(4'h2, d); check("R2 vec", int'(d), 8'h46);
        rd_now(4'h4, d); check("R2 pre hi", int'(d), 8'h00);
        rd_now(4'h5, d); check("R2 pre mid", int'(d), 8'hA5);
        rd_now(4'h6, d); check("R2 pre lo", int'(d), 8'hC3);
        rd_now(4'h3, d); check("R2 unmapped", int'(d), 0);

        // R8 vector on acknowledge
        irq_ack = 1'b1; #1;
        check("R8 vec ack", int'(vec_out), 8'h46);
        irq_ack = 1'b0; #1;
        check("R8 vec idle", int'(vec_out), 0);

        // R5 R6 period sweep
        for (int k = 0; k < 6; k++) begin
            p = (k == 5) ? 7 : k;
            wr_reg(4'h0, 8'hA0);
            wr_reg(4'h1, 8'h01);
            set_pre(p);
            wr_reg(4'h0, 8'hA1);
            e = last_edge;
            wait_irq(e + DIV * (p + 2), z1);
            check("R5 first zero", z1 - e, DIV * ((p > 0) ? p : 1));
            rd_now(4'h1, d); check("R5 status", int'(d), 1);
            wr_reg(4'h1, 8'h00);
            check("R6 write0 keeps", int'(irq_req), 1);
            wr_reg(4'h1, 8'h01);
            check("R6 clear", int'(irq_req), 0);
            wait_irq(z1 + DIV * (p + 2), z2);
            check("R5 period", z2 - z1, DIV * (p + 1));
        end
        wr_reg(4'h0, 8'hA0);
        wr_reg(4'h1, 8'h01);

        // R3 R9 R10 live count
        p = 32'h123456;
        set_pre(p);
        wr_reg(4'h0, 8'hA1);
        e = last_edge;
        rd_count(v); check("R3 load", v, p);
        wait_cyc(e + DIV - 1);
        rd_count(v); check("R3 before step", v, p);
        wait_cyc(e + DIV);
        rd_count(v); check("R3 first step", v, p - 1);
        wait_cyc(e + 3 * DIV + 5);
        rd_count(v); check("R9 live", v, p - (cyc - e) / DIV);
        wr_reg(4'hA, 8'hFF);
        wr_reg(4'h8, 8'h00);
        rd_count(v); check("R9 write ignored", v, p - (cyc - e) / DIV);
        wr_reg(4'h6, 8'h00);
        rd_count(v); check("R10 count kept", v, p - (cyc - e) / DIV);
        rd_now(4'h6, d); check("R10 pre stored", int'(d), 0);

        // R4 disable and non-prescaled clock select hold the count
        wr_reg(4'h0, 8'hA0);
        hold = p - (last_edge - e) / DIV;
        rd_count(v); check("R4 frozen", v, hold);
        wait_cyc(cyc + 100);
        rd_count(v); check("R4 still frozen", v, hold);
        wr_reg(4'h0, 8'hA3);
        wait_cyc(cyc + 100);
        rd_count(v); check("R4 clk sel hold", v, 32'h123400);

        // R7 request only in request mode
        wr_reg(4'h0, 8'h00);
        wr_reg(4'h1, 8'h01);
        set_pre(1);
        wr_reg(4'h0, 8'h01);
        e = last_edge;
        wait_cyc(e + DIV + 8);
        rd_now(4'h1, d); check("R7 status set", int'(d), 1);
        check("R7 no request", int'(irq_req), 0);
        wr_reg(4'h0, 8'hA1);
        check("R7 request", int'(irq_req), 1);
        irq_ack = 1'b1; #1;
        check("R8 vec during irq", int'(vec_out), 8'h46);
        irq_ack = 1'b0;

        // R6 set and clear in the same clock
        wr_reg(4'h0, 8'h00);
        wr_reg(4'h1, 8'h01);
        set_pre(2);
        wr_reg(4'h0, 8'hA1);
        e = last_edge;
        wait_irq(e + DIV * 4, z1);
        check("R5 zero p2", z1 - e, DIV * 2);
        wr_reg(4'h1, 8'h01);
        check("R6 clear p2", int'(irq_req), 0);
        z2 = z1 + DIV * 3;
        wait_cyc(z2 - 1);
        wr_at(4'h1, 8'h01);
        check("R6 set wins", int'(irq_req), 1);
        rd_now(4'h1, d); check("R6 flag kept", int'(d), 1);
        wr_reg(4'h1, 8'h01);
        check("R6 later clear", int'(irq_req), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule